// File: doc/BRIEF.md
# Latched Alarm Register with Interrupt Masks

This block collects four hardware alarm events into one byte-wide register that a CPU can read and write, and it drives a single active-high interrupt request. The upper nibble holds one enable per alarm and the lower nibble holds one sticky flag per alarm. A flag is set by a one-cycle pulse on its event input. It stays set until software clears it.

An enable only decides whether its flag can raise the interrupt. A flag whose enable is off is still recorded in the register, so software can poll alarms that it does not want interrupts from. Any CPU write loads all four enables from the upper nibble of the written byte. The same write clears every flag, whatever the lower nibble holds.

The four alarms are a frame-sync counting error, a receive phase realignment, a transmit phase realignment and an elastic-buffer frame slip. Their event inputs must already be synchronous to the register clock.

Top module: `alarm_register`

## Requirements
- R1: After a synchronous reset, every register bit reads 0 and `irq` is 0. With all enables at 0, every interrupt starts disabled.
- R2: A pulse on `evt_in[i]` sets register bit i. The bit can be read in the cycle after the clock edge that samples the pulse.
- R3: A set flag bit stays 1 through any number of cycles without a write.
- R4: A write (`wr_en` high for one cycle) clears all four flag bits (bits 3..0), whatever value `wr_data[3:0]` carries.
- R5: A write loads `wr_data[7:4]` into enable bits 7..4. A read (`rd_data`) always shows the enables in bits 7..4 and the flags in bits 3..0.
- R6: A flag whose enable bit is 0 still latches. While its enable is 0 it never raises `irq`.
- R7: `irq` is registered. It equals the OR over all i of (flag i AND enable i), as held in the register one clock earlier.
- R8: If an event pulse and a write happen in the same cycle, the flag for that event reads 1 afterwards.
- R9: Enable bit 4+i belongs to flag bit i: bit 7 with bit 3 (frame-sync count error), bit 6 with bit 2 (receive realignment), bit 5 with bit 1 (transmit realignment), bit 4 with bit 0 (buffer slip). No other enable can let flag i through.
- R10: Enable bits change only on a write. Event pulses never alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle CPU write strobe |
| wr_data | input | 8 (2*N_SRC) | Write byte; the upper half gives the enables |
| rd_data | output | 8 (2*N_SRC) | Enables in the upper half, flags in the lower half |
| evt_in | input | 4 (N_SRC) | One-cycle alarm event pulses |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
On every cycle, the checker tests these: an event pulse latches, a flag holds without a write, a write leaves only the flags of coincident events, enables load on a write and stay stable otherwise, and `irq` follows the enabled flags of the previous cycle. Some behaviour shows only across a sequence of steps, so only the bench scenarios cover it. These are the exact enable-to-flag pairing for each alarm, masked flags that still latch while `irq` stays low, the one-cycle lag between a flag appearing and `irq` rising, and `irq` dropping after a clearing write.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  // Index of each alarm source within the flag half of the register
  typedef enum int unsigned {
    SRC_BUF_SLIP   = 0,
    SRC_TX_REALIGN = 1,
    SRC_RX_REALIGN = 2,
    SRC_FRAME_CNT  = 3
  } alarm_src_e;

  localparam int unsigned DEF_N_SRC = 4;
endpackage

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int unsigned N_SRC = alarm_pkg::DEF_N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [N_SRC-1:0] evt,
  output logic [N_SRC-1:0] flags
);
  // One sticky bit per source; a new event wins over a clear in the same cycle
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_enable_reg.sv
module alarm_enable_reg #(
  parameter int unsigned N_SRC = alarm_pkg::DEF_N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N_SRC-1:0] din,
  output logic [N_SRC-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)       en <= '0;
    else if (load) en <= din;
  end
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen #(
  parameter int unsigned N_SRC = alarm_pkg::DEF_N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] en,
  output logic             irq
);
  logic [N_SRC-1:0] gated;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign gated[i] = flags[i] & en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |gated;
  end
endmodule

// File: rtl/alarm_register.sv
module alarm_register #(
  parameter int unsigned N_SRC = alarm_pkg::DEF_N_SRC,
  localparam int unsigned REG_W = 2 * N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_SRC-1:0] evt_in,
  output logic             irq
);
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] en;

  alarm_enable_reg #(.N_SRC(N_SRC)) u_en (
    .clk  (clk),
    .rst  (rst),
    .load (wr_en),
    .din  (wr_data[REG_W-1:N_SRC]),
    .en   (en)
  );

  alarm_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr_en),
    .evt   (evt_in),
    .flags (flags)
  );

  alarm_irq_gen #(.N_SRC(N_SRC)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .en    (en),
    .irq   (irq)
  );

  assign rd_data = {en, flags};
endmodule

// File: rtl/alarm_register_chk.sv
module alarm_register_chk #(
  parameter int unsigned N_SRC = alarm_pkg::DEF_N_SRC,
  localparam int unsigned REG_W = 2 * N_SRC
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [N_SRC-1:0] evt_in,
  input logic             irq
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && !irq);

  // R2
  event_latches_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_data[N_SRC-1:0] & $past(evt_in)) == $past(evt_in)));

  // R3
  flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_data[N_SRC-1:0] & $past(rd_data[N_SRC-1:0])) == $past(rd_data[N_SRC-1:0])));

  // R4 R8
  write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[N_SRC-1:0] == $past(evt_in)));

  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[REG_W-1:N_SRC] == $past(wr_data[REG_W-1:N_SRC])));

  // R10
  enable_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data[REG_W-1:N_SRC]));

  // R7
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(rd_data[REG_W-1:N_SRC] & rd_data[N_SRC-1:0]))));
endmodule

bind alarm_register alarm_register_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .evt_in  (evt_in),
  .irq     (irq)
);

// File: tb/test_alarm_register.sv
module test_alarm_register;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] evt_in = '0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alarm_register i_alarm_register (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All stimulus changes at the falling edge; outputs sampled there too
  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [3:0] e);
    evt_in = e; cyc(); evt_in = '0;
  endtask

  task automatic t_reset;
    check("R1 reg", rd_data, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_latch_masked;
    cpu_write(8'h00);
    pulse(4'b0100);
    check("R2 latch", rd_data, 8'h04);
    cyc(3);
    check("R3 hold", rd_data, 8'h04);
    check("R6 masked irq", {7'd0, irq}, 8'h00);
    pulse(4'b1001);
    check("R6 masked latch", rd_data, 8'h0D);
  endtask

  task automatic t_write_clear;
    cpu_write(8'hF5);
    check("R4 clear / R5 load", rd_data, 8'hF0);
    cpu_write(8'h3F);
    check("R4 clear data ones", rd_data, 8'h30);
  endtask

  task automatic t_irq_timing;
    cpu_write(8'hF0);
    cyc();
    pulse(4'b0001);
    check("R7 reg", rd_data, 8'hF1);
    check("R7 irq lag", {7'd0, irq}, 8'h00);
    cyc();
    check("R7 irq rise", {7'd0, irq}, 8'h01);
    cpu_write(8'hF0);
    check("R7 irq hold one", {7'd0, irq}, 8'h01);
    cyc();
    check("R7 irq fall", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pairing;
    for (int i = 0; i < 4; i++) begin
      cpu_write(8'(1 << (4 + ((i + 1) % 4))));
      pulse(4'(1 << i));
      cyc();
      check($sformatf("R9 wrong pair %0d", i), {7'd0, irq}, 8'h00);
      cpu_write(8'(1 << (4 + i)));
      pulse(4'(1 << i));
      cyc();
      check($sformatf("R9 right pair %0d", i), {7'd0, irq}, 8'h01);
    end
    cpu_write(8'h00);
    cyc();
  endtask

  task automatic t_collide;
    wr_en = 1'b1; wr_data = 8'h84; evt_in = 4'b1000;
    cyc();
    wr_en = 1'b0; wr_data = '0; evt_in = '0;
    check("R8 event kept", rd_data, 8'h88);
    cyc();
    check("R8 irq", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_enable_stable;
    cpu_write(8'hA0);
    pulse(4'b1111);
    pulse(4'b0101);
    cyc(2);
    check("R10 enables", rd_data, 8'hAF);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_latch_masked();
    t_write_clear();
    t_irq_timing();
    t_pairing();
    t_collide();
    t_enable_stable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule